// File: doc/BRIEF.md
# Dual-Bank FIR Filter with Crossfaded Bank Switching

This block runs a stream of 24-bit audio samples through a 32-tap FIR filter whose coefficients live in two banks. One bank drives the output while the other sits idle and can be refilled from an external coefficient store through a write port addressed by bank and tap. Both banks are evaluated for every input sample. This lets a bank change fade smoothly instead of switching abruptly and producing a click.

A swap command makes the idle bank the new active one and starts a linear crossfade of 256 output samples from the old filter result to the new one. During the crossfade the block raises a busy flag. While busy is high, further swap commands and all coefficient writes are dropped. One serial multiply-accumulate pass per sample walks the taps for both banks side by side. The two accumulators are then weighted, rounded and saturated to 24 bits. Input samples must be spaced far enough apart for the pass to finish.

Top module: `dual_bank_fir`

## Requirements
- R1: After reset, bank 0 is active, every coefficient of both banks is zero, `busy_o` and `out_valid_o` are low and `out_data_o` is zero.
- R2: Each accepted `in_valid_i` pulse produces exactly one `out_valid_o` pulse of one cycle, TAPS+2 clock cycles later. Pulses on `in_valid_i` must be at least TAPS+3 cycles apart.
- R3: Outside a crossfade, the output is round-half-up(sum over k of c[k]·x[n−k] / 2^17) from the active bank. Coefficients are signed Q1.17, and tap k weights the sample k inputs old (tap 0 is the newest).
- R4: A write with `coef_we_i` high stores `coef_data_i` at tap `coef_tap_i` of bank `coef_bank_i` (0 or 1) only if that bank is idle and `busy_o` is low. Writes to the active bank, and any write during a crossfade, are discarded. Writes to the idle bank do not change the output.
- R5: A `swap_i` pulse while `busy_o` is low makes the idle bank active and raises `busy_o` on the next cycle.
- R6: The k-th output after an accepted swap (k = 0..255) equals round-half-up((new·k + old·(256−k)) / 2^25), where new and old are the raw accumulator sums of the new and old bank.
- R7: A `swap_i` pulse while `busy_o` is high is ignored. The active bank and the blend sequence continue unchanged.
- R8: Every output value is saturated to the range −2^23 .. 2^23−1.
- R9: `busy_o` falls together with the 256th blended output. From the next output on, only the new bank contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 24 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 24 | Signed, rounded and saturated output sample |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_bank_i | input | 1 | Target bank of the write |
| coef_tap_i | input | 5 | Target tap of the write |
| coef_data_i | input | 18 | Signed Q1.17 coefficient |
| swap_i | input | 1 | Request to switch banks with a crossfade |
| busy_o | output | 1 | High while a crossfade is in progress |

## Verification
The bound checker watches on every cycle that output timing follows input timing (R2) and that inputs respect the spacing rule. It also checks that an accepted swap flips the bank and raises busy (R5), that a swap during busy leaves the bank alone (R7), and that busy drops exactly with the 256th blended output (R9). The arithmetic needs the bench's scoreboard, which runs a separate integer model of both banks and the blend weight: the steady-state sums, the ramp values, rounding and saturation (R3, R6, R8), and the fact that rejected or idle-bank writes leave the output untouched (R4).

// File: rtl/fir_xf_pkg.sv
package fir_xf_pkg;
  localparam int unsigned DEF_TAPS   = 32;
  localparam int unsigned DEF_SMP_W  = 24;
  localparam int unsigned DEF_COEF_W = 18;
  localparam int unsigned DEF_FADE   = 256;
  localparam int unsigned DEF_FRAC_W = 17;

  typedef enum logic {BANK_0 = 1'b0, BANK_1 = 1'b1} bank_e;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int unsigned TAPS   = 32,
  parameter int unsigned COEF_W = 18,
  localparam int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         widx_i,
  input  logic signed [COEF_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]         ridx_i,
  output logic signed [COEF_W-1:0] rdata_o
);
  logic signed [COEF_W-1:0] mem_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int unsigned TAPS   = 32,
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned COEF_W = 18,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned PROD_W = SMP_W + COEF_W,
  localparam int unsigned ACC_W = PROD_W + IDX_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [SMP_W-1:0]  in_data_i,
  input  logic signed [COEF_W-1:0] coef_a_i,
  input  logic signed [COEF_W-1:0] coef_b_i,
  output logic [IDX_W-1:0]         idx_o,
  output logic                     done_o,
  output logic signed [ACC_W-1:0]  acc_a_o,
  output logic signed [ACC_W-1:0]  acc_b_o
);
  logic signed [SMP_W-1:0] dl_q [TAPS];
  logic [IDX_W-1:0]        idx_q;
  logic                    run_q, done_q;
  logic signed [ACC_W-1:0] acc_a_q, acc_b_q;
  logic signed [PROD_W-1:0] prod_a, prod_b;

  assign prod_a = coef_a_i * dl_q[idx_q];
  assign prod_b = coef_b_i * dl_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) dl_q[i] <= '0;
      idx_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      acc_a_q <= '0;
      acc_b_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (in_valid_i && !run_q) begin
        dl_q[0] <= in_data_i;
        for (int i = 1; i < TAPS; i++) dl_q[i] <= dl_q[i-1];
        acc_a_q <= '0;
        acc_b_q <= '0;
        idx_q   <= '0;
        run_q   <= 1'b1;
      end else if (run_q) begin
        acc_a_q <= acc_a_q + {{(ACC_W-PROD_W){prod_a[PROD_W-1]}}, prod_a};
        acc_b_q <= acc_b_q + {{(ACC_W-PROD_W){prod_b[PROD_W-1]}}, prod_b};
        if (idx_q == IDX_W'(TAPS-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign idx_o   = idx_q;
  assign done_o  = done_q;
  assign acc_a_o = acc_a_q;
  assign acc_b_o = acc_b_q;
endmodule

// File: rtl/fir_xfade_mix.sv
module fir_xfade_mix #(
  parameter int unsigned ACC_W  = 47,
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned FRAC_W = 17,
  parameter int unsigned FADE   = 256,
  localparam int unsigned G_W   = $clog2(FADE) + 1,
  localparam int unsigned MIX_W = ACC_W + G_W + 1,
  localparam int unsigned SH    = FRAC_W + $clog2(FADE)
) (
  input  logic signed [ACC_W-1:0] acc_new_i,
  input  logic signed [ACC_W-1:0] acc_old_i,
  input  logic [G_W-1:0]          w_new_i,
  output logic signed [SMP_W-1:0] y_o
);
  localparam logic signed [MIX_W-1:0] HALF = MIX_W'(1) << (SH - 1);
  localparam logic signed [MIX_W-1:0] MAXV = (MIX_W'(1) << (SMP_W - 1)) - MIX_W'(1);
  localparam logic signed [MIX_W-1:0] MINV = -MAXV - MIX_W'(1);

  logic [G_W-1:0]          w_old;
  logic signed [MIX_W-1:0] a_new, a_old, g_new, g_old, mix, scaled;

  always_comb begin
    w_old  = G_W'(FADE) - w_new_i;
    a_new  = {{(MIX_W-ACC_W){acc_new_i[ACC_W-1]}}, acc_new_i};
    a_old  = {{(MIX_W-ACC_W){acc_old_i[ACC_W-1]}}, acc_old_i};
    g_new  = {{(MIX_W-G_W){1'b0}}, w_new_i};
    g_old  = {{(MIX_W-G_W){1'b0}}, w_old};
    mix    = a_new * g_new + a_old * g_old;
    scaled = (mix + HALF) >>> SH;
    if (scaled > MAXV)      y_o = MAXV[SMP_W-1:0];
    else if (scaled < MINV) y_o = MINV[SMP_W-1:0];
    else                    y_o = scaled[SMP_W-1:0];
  end
endmodule

// File: rtl/dual_bank_fir.sv
module dual_bank_fir
  import fir_xf_pkg::*;
#(
  parameter int unsigned TAPS   = DEF_TAPS,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned COEF_W = DEF_COEF_W,
  parameter int unsigned FADE   = DEF_FADE,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned ACC_W = SMP_W + COEF_W + IDX_W,
  localparam int unsigned CNT_W = $clog2(FADE),
  localparam int unsigned G_W   = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [SMP_W-1:0]  in_data_i,
  output logic              out_valid_o,
  output logic [SMP_W-1:0]  out_data_o,
  input  logic              coef_we_i,
  input  logic              coef_bank_i,
  input  logic [IDX_W-1:0]  coef_tap_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic              swap_i,
  output logic              busy_o
);
  bank_e                    act_q;
  logic                     fade_q;
  logic [CNT_W-1:0]         g_q;
  logic [IDX_W-1:0]         rd_idx;
  logic signed [COEF_W-1:0] coef_rd [2];
  logic                     eng_done;
  logic signed [ACC_W-1:0]  acc_a, acc_b, acc_new, acc_old;
  logic [G_W-1:0]           w_new;
  logic signed [SMP_W-1:0]  mix_y;
  logic                     out_valid_q;
  logic [SMP_W-1:0]         out_data_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we;
    // only the idle bank, and only outside a crossfade
    assign bank_we = coef_we_i && (coef_bank_i == 1'(b)) &&
                     (act_q != bank_e'(b)) && !fade_q;
    fir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .widx_i  (coef_tap_i),
      .wdata_i (coef_data_i),
      .ridx_i  (rd_idx),
      .rdata_o (coef_rd[b])
    );
  end

  fir_mac_engine #(.TAPS(TAPS), .SMP_W(SMP_W), .COEF_W(COEF_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .coef_a_i   (coef_rd[0]),
    .coef_b_i   (coef_rd[1]),
    .idx_o      (rd_idx),
    .done_o     (eng_done),
    .acc_a_o    (acc_a),
    .acc_b_o    (acc_b)
  );

  assign acc_new = (act_q == BANK_1) ? acc_b : acc_a;
  assign acc_old = (act_q == BANK_1) ? acc_a : acc_b;
  assign w_new   = fade_q ? {1'b0, g_q} : G_W'(FADE);

  fir_xfade_mix #(.ACC_W(ACC_W), .SMP_W(SMP_W), .FRAC_W(FRAC_W), .FADE(FADE)) u_mix (
    .acc_new_i (acc_new),
    .acc_old_i (acc_old),
    .w_new_i   (w_new),
    .y_o       (mix_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= BANK_0;
      fade_q <= 1'b0;
      g_q    <= '0;
    end else if (swap_i && !fade_q) begin
      act_q  <= bank_e'(~act_q);
      fade_q <= 1'b1;
      g_q    <= '0;
    end else if (fade_q && eng_done) begin
      g_q <= g_q + 1'b1;
      if (g_q == CNT_W'(FADE-1)) fade_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= eng_done;
      if (eng_done) out_data_q <= mix_y;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign busy_o      = fade_q;
endmodule

// File: rtl/dual_bank_fir_chk.sv
module dual_bank_fir_chk #(
  parameter int unsigned TAPS = 32,
  parameter int unsigned FADE = 256,
  localparam int unsigned LAT_W = $clog2(TAPS + 3) + 1,
  localparam int unsigned BC_W  = $clog2(FADE) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic out_valid_o,
  input logic swap_i,
  input logic busy_o,
  input logic act_bank
);
  logic [LAT_W-1:0] lat_q;
  logic [BC_W-1:0]  blend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (in_valid_i)        lat_q <= LAT_W'(1);
    else if (out_valid_o)       lat_q <= '0;
    else if (lat_q != '0)       lat_q <= lat_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      blend_q <= '0;
    else if (swap_i && !busy_o)       blend_q <= '0;
    else if (out_valid_o && busy_o)   blend_q <= blend_q + 1'b1;
  end

  // R2
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> lat_q == LAT_W'(TAPS + 2));
  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> lat_q == '0);
  // R5
  a_r5_swap_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !busy_o) |=> (busy_o && act_bank != $past(act_bank)));
  // R7
  a_r7_swap_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && busy_o) |=> $stable(act_bank));
  // R9
  a_r9_fade_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (out_valid_o && blend_q == BC_W'(FADE - 1)));
endmodule

bind dual_bank_fir dual_bank_fir_chk #(.TAPS(TAPS), .FADE(FADE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .swap_i      (swap_i),
  .busy_o      (busy_o),
  .act_bank    (act_q)
);

// File: tb/dual_bank_fir_bench.sv
`timescale 1ns/1ps
module dual_bank_fir_bench;
  localparam int TAPS = 32;
  localparam int FADE = 256;
  localparam int GAP  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic [23:0] out_data;
  logic        coef_we = 1'b0;
  logic        coef_bank = 1'b0;
  logic [4:0]  coef_tap = '0;
  logic [17:0] coef_data = '0;
  logic        swap = 1'b0;
  logic        busy;

  always #2 clk = ~clk;

  dual_bank_fir u_dual_bank_fir (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .coef_we_i(coef_we), .coef_bank_i(coef_bank),
    .coef_tap_i(coef_tap), .coef_data_i(coef_data),
    .swap_i(swap), .busy_o(busy)
  );

  int     n_chk = 0, n_fail = 0;
  bit     finished = 0;
  longint cf [2][TAPS];
  longint hist [TAPS];
  int     active = 0;
  bit     fading = 0;
  int     gcnt = 0;
  int unsigned seed = 32'h1234_5678;
  longint exp_q [$];
  string  tag_q [$];

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_coef(int bank, int tap, longint val);
    @(negedge clk);
    coef_we = 1'b1; coef_bank = 1'(bank); coef_tap = 5'(tap); coef_data = 18'(val);
    @(negedge clk);
    coef_we = 1'b0;
    // R4: only idle bank, only outside a crossfade
    if (bank != active && !fading) cf[bank][tap] = val;
  endtask

  task automatic do_swap();
    @(negedge clk);
    swap = 1'b1;
    @(negedge clk);
    swap = 1'b0;
    if (!fading) begin
      active = 1 - active; fading = 1; gcnt = 0;
    end
    check(fading ? "R5 busy after swap" : "R7", longint'(busy), 1);
  endtask

  task automatic send(longint x, string tag);
    longint acc [2];
    longint wn, mix, y;
    string  t;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    for (int b = 0; b < 2; b++) begin
      acc[b] = 0;
      for (int k = 0; k < TAPS; k++) acc[b] += cf[b][k] * hist[k];
    end
    wn  = fading ? longint'(gcnt) : longint'(FADE);
    mix = acc[active] * wn + acc[1-active] * (FADE - wn);
    y   = (mix + (longint'(1) <<< 24)) >>> 25;
    t   = tag;
    if (fading) t = "R6 blend";
    if (y > 8388607)       begin y = 8388607;  t = {t, " R8 sat+"}; end
    else if (y < -8388608) begin y = -8388608; t = {t, " R8 sat-"}; end
    exp_q.push_back(y);
    tag_q.push_back(t);
    if (fading) begin
      gcnt++;
      if (gcnt == FADE) fading = 0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = x[23:0];
    @(negedge clk);
    in_valid = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  function automatic longint rnd_smp();
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'($signed(seed[30:7]));
  endfunction

  // monitor: pop and compare
  always @(negedge clk) begin : mon
    longint e;
    string  t;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected output", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, longint'($signed(out_data)), e);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < TAPS; k++) cf[b][k] = 0;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 busy", longint'(busy), 0);
    check("R1 out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: bank 0 active after reset, write is dropped
    write_coef(0, 0, 131072 - 1);
    send(1000, "R4 active write dropped");
    send(-5000, "R1 zero coefs");
    // R4: idle-bank writes, invisible on output
    write_coef(1, 0, 65536);
    write_coef(1, 1, -32768);
    write_coef(1, 5, 100000);
    write_coef(1, 31, 131071);
    write_coef(1, 7, -131072);
    for (int i = 0; i < 6; i++) send(rnd_smp(), "R4 idle write hidden");

    // crossfade 0 -> 1
    do_swap();
    for (int i = 0; i < 100; i++) send(rnd_smp(), "R6");
    do_swap();                               // R7 ignored
    check("R7 bank kept", longint'(active), 1);
    write_coef(0, 0, 131071);                // R4 dropped during fade
    for (int i = 100; i < FADE; i++) send(rnd_smp(), "R6");
    check("R9 busy low after fade", longint'(busy), 0);
    for (int i = 0; i < 12; i++) send(rnd_smp(), "R3 steady bank1");
    send(0, "R3 zero in");

    // R8: large coefficients in bank 0, crossfade into saturation
    for (int k = 0; k < 4; k++) write_coef(0, k, 131071);
    write_coef(0, 4, -131072);
    write_coef(1, 2, 5);                     // R4 active bank dropped
    do_swap();
    for (int i = 0; i < FADE; i++)
      send((i % 2 == 0) ? 8388607 : -8388608 + i, "R6");
    check("R9 busy low after second fade", longint'(busy), 0);
    for (int i = 0; i < 6; i++) send(8388607, "R8 steady");
    for (int i = 0; i < 6; i++) send(-8388608, "R8 steady");
    for (int i = 0; i < 8; i++) send(rnd_smp() >>> 3, "R3 steady bank0");

    repeat (GAP) @(negedge clk);
    check("R2 all outputs seen", longint'(exp_q.size()), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule